// File: doc/BRIEF.md
# Infrared Serial Receive Decoder and Character Sampler

This block sits behind an infrared receiver that signals each zero bit with a short low pulse and each one bit with no pulse. It first brings the raw pin into the clock domain. It then widens every detected falling edge into a low level that lasts one full bit time on a decoded line. A character sampler watches that decoded line, locks its bit phase to the falling edge of each start bit, and reads every bit at the middle of its bit time. The sampler then delivers one byte together with a single-clock valid strobe and a framing-error flag.

All timing runs on a clock enable, `tick`, that pulses at sixteen times the bit rate (one bit time is `TICKS_PER_BIT` ticks). The block is meant for a system clock that is faster than the bit clock. The transmit path, buffering, baud generation and register access belong to other blocks.

Top module: `irsir_rx_decoder`

## Requirements
- R1: After reset, `dec_line` is 1, `rx_valid` is 0 and `frame_err` is 0.
- R2: An isolated falling edge on `ir_rx` (the pin idles high) drives `dec_line` low for exactly `TICKS_PER_BIT` ticks. `dec_line` then returns high.
- R3: A new falling edge that arrives while the low stretch is running restarts the full stretch. Zero bits spaced exactly one bit time apart therefore give one continuous low level, whose length is the number of zero bits times `TICKS_PER_BIT` ticks.
- R4: When a late edge leaves a one-tick high pulse on `dec_line` between two zero bits, the received byte is unaffected.
- R5: The sampler takes its first sample `TICKS_PER_BIT/2` ticks after the tick on which it first sees `dec_line` low while idle. It takes every later sample `TICKS_PER_BIT` ticks after the one before, ending with the stop-bit sample. `rx_valid` therefore rises `TICKS_PER_BIT/2 + (DATA_BITS+1)*TICKS_PER_BIT + 1` ticks after `dec_line` falls.
- R6: A character is one start bit of 0, then `DATA_BITS` data bits with the least significant bit first, then a stop bit of 1. On `ir_rx` a 0 bit is a low pulse near the start of its bit time and a 1 bit is a high level for the whole bit. `rx_byte` holds the data bits with bit 0 being the first received.
- R7: `rx_valid` is high for exactly one clock after each stop-bit sample.
- R8: `frame_err` is 1 when the stop-bit sample read 0 and 0 when it read 1. It is updated only in the cycle in which `rx_valid` is high and holds its value until the next character.
- R9: After a framing error the sampler waits until `dec_line` is high again before it accepts a new start bit. The next well-formed character is then received correctly.
- R10: Nothing advances on a clock in which `tick` is 0. All timing is counted in ticks, not clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable at sixteen times the bit rate |
| ir_rx | input | 1 | Raw infrared receive pin, idles high |
| dec_line | output | 1 | Decoded serial line after pulse stretching |
| rx_byte | output | DATA_BITS | Last received character |
| rx_valid | output | 1 | One-clock strobe with each received character |
| frame_err | output | 1 | Stop bit of the last character read as 0 |

## Verification
The bench builds the block with its default parameters: sixteen ticks per bit, eight data bits and a two-stage synchroniser. It drives `tick` on every second clock, so every latency and run length is checked in ticks scaled by two, and a design that counts clocks instead of ticks shows up. With eight data bits, one all-zero character produces a nine-bit continuous low level, which exercises the stretch retrigger. A deliberately lengthened bit inside that character places a one-tick glitch between zeros, well away from the mid-bit samples.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP,
    S_WAIT_HIGH
  } samp_state_e;

  // Phase value loaded at the start edge: the first sample lands t/2 ticks later.
  function automatic int unsigned mid_load(input int unsigned t);
    return t / 2 - 1;
  endfunction

  // Phase value loaded after each sample: the next sample lands t ticks later.
  function automatic int unsigned full_load(input int unsigned t);
    return t - 1;
  endfunction

  // Ticks from the decoded start fall to the valid strobe.
  function automatic int unsigned frame_latency(input int unsigned t, input int unsigned bits);
    return t / 2 + (bits + 1) * t + 1;
  endfunction

endpackage

// File: rtl/irsir_sync.sv
module irsir_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/irsir_stretch.sv
module irsir_stretch #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_s,
  output logic dec_line
);
  localparam int CW = $clog2(TICKS_PER_BIT + 1);

  logic          prev;
  logic [CW-1:0] cnt;
  logic          edge_fall;

  assign edge_fall = tick && prev && !rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b1;
      cnt  <= '0;
    end else if (tick) begin
      prev <= rx_s;
      if (edge_fall)     cnt <= CW'(TICKS_PER_BIT);
      else if (cnt != 0) cnt <= cnt - 1'b1;
    end
  end

  assign dec_line = (cnt == '0);

  AST_FALL_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |=> !dec_line); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TICKS_PER_BIT)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R10
endmodule

// File: rtl/irsir_sampler.sv
module irsir_sampler
  import irsir_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_BITS     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 dec_line,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 frame_err
);
  localparam int PW = $clog2(TICKS_PER_BIT);
  localparam int BW = $clog2(DATA_BITS + 1);
  localparam logic [PW-1:0] PH_MID  = PW'(mid_load(TICKS_PER_BIT));
  localparam logic [PW-1:0] PH_FULL = PW'(full_load(TICKS_PER_BIT));

  samp_state_e          state;
  logic                 dec_prev;
  logic [PW-1:0]        ph;
  logic [BW-1:0]        bit_cnt;
  logic [DATA_BITS-1:0] shreg;
  logic                 start_edge;
  logic                 strobe;

  assign start_edge = tick && (state == S_IDLE) && dec_prev && !dec_line;
  assign strobe = tick && (ph == '0) &&
                  (state == S_START || state == S_DATA || state == S_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      dec_prev  <= 1'b1;
      ph        <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
      rx_byte   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        dec_prev <= dec_line;
        case (state)
          S_IDLE: begin
            if (start_edge) begin
              state <= S_START;
              ph    <= PH_MID;
            end
          end
          S_START, S_DATA, S_STOP: begin
            if (ph != '0) begin
              ph <= ph - 1'b1;
            end else begin
              ph <= PH_FULL;
              if (state == S_START) begin
                if (dec_line) state <= S_IDLE;
                else begin
                  state   <= S_DATA;
                  bit_cnt <= '0;
                end
              end else if (state == S_DATA) begin
                shreg   <= {dec_line, shreg[DATA_BITS-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BW'(DATA_BITS - 1)) state <= S_STOP;
              end else begin
                rx_byte   <= shreg;
                rx_valid  <= 1'b1;
                frame_err <= !dec_line;
                state     <= dec_line ? S_IDLE : S_WAIT_HIGH;
              end
            end
          end
          S_WAIT_HIGH: begin
            if (dec_line) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7
  AST_ERR_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err != $past(frame_err)) |-> rx_valid); // R8
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(strobe)); // R5
  AST_NO_START_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_HIGH && !dec_line) |=> state != S_START); // R9
endmodule

// File: rtl/irsir_rx_decoder.sv
module irsir_rx_decoder #(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_BITS     = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 ir_rx,
  output logic                 dec_line,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 frame_err
);
  logic rx_sync;

  irsir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ir_rx),
    .q     (rx_sync)
  );

  irsir_stretch #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rx_s     (rx_sync),
    .dec_line (dec_line)
  );

  irsir_sampler #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_BITS(DATA_BITS)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .dec_line  (dec_line),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .frame_err (frame_err)
  );
endmodule

// File: tb/tb_irsir_rx_decoder.sv
module tb_irsir_rx_decoder;
  localparam int T    = 16;
  localparam int DB   = 8;
  localparam int DIV  = 2;
  localparam int LAT  = DIV * (T / 2 + (DB + 1) * T + 1);
  localparam int WDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          ir_rx = 1'b1;
  logic          dec_line;
  logic [DB-1:0] rx_byte;
  logic          rx_valid;
  logic          frame_err;

  irsir_rx_decoder #(.TICKS_PER_BIT(T), .DATA_BITS(DB), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ir_rx(ir_rx),
    .dec_line(dec_line), .rx_byte(rx_byte), .rx_valid(rx_valid), .frame_err(frame_err)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int total  = 0;
  logic [DB:0] expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick enable: one clock in DIV
  int tdiv = 0;
  always @(negedge clk) begin
    tick <= (tdiv == 0);
    tdiv = (tdiv + 1) % DIV;
  end

  // monitor state
  bit prev_dec = 1'b1;
  bit prev_valid = 1'b0;
  int low_len = 0, high_len = 0, last_low = 0, glitches = 0;
  bit armed = 1'b0;
  int lat = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dec_line) begin
        low_len++;
        if (prev_dec) begin
          if (high_len == DIV) glitches++;
          high_len = 0;
        end
      end else begin
        high_len++;
        if (!prev_dec) begin
          last_low = low_len;
          low_len = 0;
        end
      end
      if (!armed && prev_dec && !dec_line) begin
        armed = 1'b1;
        lat = 0;
      end else if (armed) lat++;
      if (rx_valid) begin
        chk(!prev_valid, "R7 valid single clock", int'(prev_valid), 0);
        chk(lat == LAT, "R5 R10 valid latency in clocks", lat, LAT);
        armed = 1'b0;
        if (expq.size() == 0) begin
          chk(1'b0, "R6 unexpected byte", int'(rx_byte), -1);
        end else begin
          logic [DB:0] e;
          e = expq.pop_front();
          chk(rx_byte == e[DB-1:0], "R6 byte value", int'(rx_byte), int'(e[DB-1:0]));
          chk(frame_err == e[DB], "R8 frame_err with byte", int'(frame_err), int'(e[DB]));
        end
      end
      prev_dec = dec_line;
      prev_valid = rx_valid;
    end
  end

  task automatic idle_bits(input int n);
    for (int i = 0; i < n * T * DIV; i++) begin
      @(negedge clk);
      ir_rx = 1'b1;
    end
  endtask

  // Encodes one character; bit index long_bit lasts one extra tick.
  task automatic send_frame(input logic [DB-1:0] b, input bit bad_stop, input int long_bit);
    expq.push_back({bad_stop, b});
    for (int k = 0; k < DB + 2; k++) begin
      bit zero;
      int len;
      if (k == 0) zero = 1'b1;
      else if (k == DB + 1) zero = bad_stop;
      else zero = !b[k-1];
      len = T + ((k == long_bit) ? 1 : 0);
      for (int t = 0; t < len; t++) begin
        for (int d = 0; d < DIV; d++) begin
          @(negedge clk);
          ir_rx = (zero && t < 3) ? 1'b0 : 1'b1;
        end
      end
    end
    idle_bits(2);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(dec_line == 1'b1, "R1 dec_line after reset", int'(dec_line), 1);
    chk(rx_valid == 1'b0, "R1 rx_valid after reset", int'(rx_valid), 0);
    chk(frame_err == 1'b0, "R1 frame_err after reset", int'(frame_err), 0);
    rst_n = 1'b1;
    idle_bits(2);
    chk(rx_valid == 1'b0 && expq.size() == 0, "R6 idle line gives no byte", int'(rx_valid), 0);

    send_frame(8'hFF, 1'b0, -1);
    chk(last_low == T * DIV, "R2 isolated stretch length", last_low, T * DIV);

    send_frame(8'h00, 1'b0, -1);
    chk(last_low == (DB + 1) * T * DIV, "R3 continuous low for zeros", last_low, (DB + 1) * T * DIV);
    chk(glitches == 0, "R3 no glitch at exact spacing", glitches, 0);

    send_frame(8'h55, 1'b0, -1);
    send_frame(8'hA3, 1'b0, -1);
    send_frame(8'h80, 1'b0, -1);

    send_frame(8'h00, 1'b0, 3);
    chk(glitches >= 1, "R4 glitch stimulus present", glitches, 1);

    send_frame(8'h5A, 1'b1, -1);
    chk(frame_err == 1'b1, "R8 frame_err held after bad stop", int'(frame_err), 1);
    idle_bits(1);
    send_frame(8'h3C, 1'b0, -1);
    chk(frame_err == 1'b0, "R9 recovery after framing error", int'(frame_err), 0);
    send_frame(8'h01, 1'b0, -1);

    chk(expq.size() == 0, "R6 all bytes delivered", expq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end
endmodule